// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Synchronous SRAM Model

This block is a synthesizable model of a synchronous static memory with one read port and one write port that can both accept a command in the same command cycle. Every access moves exactly two data words. The double-data-rate behaviour is modelled on a single clock that runs at twice the command rate. An internal phase flag, `k_half`, marks the first half of each command cycle (K half) and the second half (K# half). The flag is brought out so that the host can align its commands to it.

A command is issued in a K half. Read address, read request, write request, first-beat byte enables and first-beat write data are taken at the edge that ends that half. The write address, second-beat byte enables and second-beat write data follow in the K# half. The write data therefore arrives half a cycle before its address. It is kept in a small internal buffer, and the finished write is held there for one more command cycle before it is committed to the array. Reads merge that buffered write byte by byte, so they always see every earlier write.

Read data comes back on a fixed pipeline. The first beat appears 1.5 command cycles after the command and the second beat half a cycle later. A valid flag marks both beats. The data bus holds its last value while the flag is low.

Top module: `burst2_qsram`

## Requirements
- R1: While `rst` is high at a clock edge, and in the clock period after the last such edge, `k_half` reads 1, `dout_vld` reads 0 and `dout` reads 0. Reset does not alter the array contents.
- R2: `k_half` alternates 1, 0, 1, 0 on every clock after reset. `rd_req`, `wr_req` and `rd_pair` are sampled only at an edge that ends a period with `k_half` = 1. A request raised while `k_half` = 0 produces no read beats and changes no stored word.
- R3: A write takes `wr_req`, beat-0 `lane_we` and beat-0 `din` at its command edge. It takes `wr_pair`, beat-1 `lane_we` and beat-1 `din` at the next edge, which ends the following K# period.
- R4: Pair address A names words 2A and 2A+1. Beat 0 of every read or write maps to word 2A and beat 1 to word 2A+1. Every access moves exactly two beats.
- R5: Bit i of `lane_we` covers `din[i*LANE_W +: LANE_W]` for the beat being sampled. A lane whose bit is 0 keeps its stored value. A write with every bit 0 leaves the pair unchanged.
- R6: If the command edge of a read is edge n, beat 0 is on `dout` with `dout_vld` = 1 in the period after edge n+3, and beat 1 is there in the period after edge n+4.
- R7: `dout_vld` is 0 in every period that carries no read beat, and `dout` keeps its previous value in such a period.
- R8: A read and a write issued in the same command cycle are served independently. A read of the pair being written in that same cycle returns the contents from before that write.
- R9: A read returns the result of every write whose command cycle came earlier, including a write issued in the immediately preceding command cycle that is still held in the buffer.
- R10: Reads issued in consecutive command cycles give an unbroken run of valid beats, two per read, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the command rate |
| rst | input | 1 | Synchronous reset, active high |
| k_half | output | 1 | 1 in the first half of a command cycle, 0 in the second |
| rd_req | input | 1 | Read request, sampled at the end of a K half |
| rd_pair | input | WORD_AW-1 | Read pair address, sampled with `rd_req` |
| wr_req | input | 1 | Write request, sampled at the end of a K half |
| wr_pair | input | WORD_AW-1 | Write pair address, sampled at the end of the following K# half |
| lane_we | input | LANES | Per-lane write enables for the beat being sampled |
| din | input | LANES*LANE_W | Write data for the beat being sampled |
| dout | output | LANES*LANE_W | Read data, one beat per clock |
| dout_vld | output | 1 | Marks a read beat on `dout` |

## Verification
The assertions assume that the host presents commands only in step with `k_half`. They also assume that `rd_req` and `wr_req` are low during reset, so that no request seen in the last cycles before reset shows up as a pipeline token. The bench drives every command after waiting for a falling edge with `k_half` high. It issues its deliberately misplaced requests only in K# halves, and it keeps every request low while reset is applied. The bench first writes every pair, so that no read returns an unwritten word. Random traffic is then confined to eight pairs so that same-cycle and back-to-back collisions occur often.

// File: rtl/b2q_pkg.sv
package b2q_pkg;

   // Which half of a command cycle the current clock period belongs to.
   typedef enum logic {
      PH_KBAR = 1'b0,
      PH_K    = 1'b1
   } b2q_phase_e;

   // Read beats leave the pipe this many edges after the command edge.
   localparam int B2Q_FIRST_BEAT_EDGES = 3;

endpackage

// File: rtl/b2q_store.sv
module b2q_store #(
   parameter  int PAIR_AW = 9,
   parameter  int LANES   = 2,
   parameter  int LANE_W  = 9,
   localparam int DW      = LANES * LANE_W,
   localparam int PAIRS   = 1 << PAIR_AW
) (
   input  logic               clk,
   input  logic               we,
   input  logic [PAIR_AW-1:0] wpair,
   input  logic [LANES-1:0]   wbe0,
   input  logic [LANES-1:0]   wbe1,
   input  logic [DW-1:0]      wd0,
   input  logic [DW-1:0]      wd1,
   input  logic [PAIR_AW-1:0] rpair,
   output logic [DW-1:0]      rd0,
   output logic [DW-1:0]      rd1
);

   // One narrow array per lane and beat, so that each lane has a single writer.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] even_q [PAIRS];
      logic [LANE_W-1:0] odd_q  [PAIRS];

      always_ff @(posedge clk) begin
         if (we && wbe0[l]) even_q[wpair] <= wd0[l*LANE_W +: LANE_W];
         if (we && wbe1[l]) odd_q[wpair]  <= wd1[l*LANE_W +: LANE_W];
      end

      assign rd0[l*LANE_W +: LANE_W] = even_q[rpair];
      assign rd1[l*LANE_W +: LANE_W] = odd_q[rpair];
   end

endmodule

// File: rtl/b2q_wbuf.sv
module b2q_wbuf #(
   parameter  int PAIR_AW = 9,
   parameter  int LANES   = 2,
   parameter  int LANE_W  = 9,
   localparam int DW      = LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               k_half,
   input  logic               wr_req,
   input  logic [PAIR_AW-1:0] wr_pair,
   input  logic [LANES-1:0]   lane_we,
   input  logic [DW-1:0]      din,
   output logic               pend_v,
   output logic [PAIR_AW-1:0] pend_pair,
   output logic [LANES-1:0]   pend_be0,
   output logic [LANES-1:0]   pend_be1,
   output logic [DW-1:0]      pend_d0,
   output logic [DW-1:0]      pend_d1,
   output logic               commit_we
);

   // Beat-0 staging: data arrives half a cycle ahead of its address.
   logic             early_v;
   logic [LANES-1:0] early_be;
   logic [DW-1:0]    early_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         early_v <= 1'b0;
         pend_v  <= 1'b0;
      end else if (k_half) begin
         early_v <= wr_req;
      end else begin
         early_v <= 1'b0;
         pend_v  <= early_v;
      end
   end

   always_ff @(posedge clk) begin
      if (k_half) begin
         early_be <= lane_we;
         early_d  <= din;
      end else if (early_v) begin
         pend_pair <= wr_pair;
         pend_be0  <= early_be;
         pend_d0   <= early_d;
         pend_be1  <= lane_we;
         pend_d1   <= din;
      end
   end

   // The held write drains to the array at the next K# edge, the same edge
   // that loads its successor (if any).
   assign commit_we = pend_v & ~k_half & ~rst;

   AST_PEND_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_v) |-> $past(wr_req && k_half, 2)); // R3

   AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (pend_v && !k_half && !early_v) |=> !pend_v); // R9

endmodule

// File: rtl/b2q_rpipe.sv
module b2q_rpipe #(
   parameter  int PAIR_AW = 9,
   parameter  int LANES   = 2,
   parameter  int LANE_W  = 9,
   localparam int DW      = LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               k_half,
   input  logic               rd_req,
   input  logic [PAIR_AW-1:0] rd_pair,
   output logic [PAIR_AW-1:0] look_pair,
   input  logic [DW-1:0]      arr0,
   input  logic [DW-1:0]      arr1,
   input  logic               pend_v,
   input  logic [PAIR_AW-1:0] pend_pair,
   input  logic [LANES-1:0]   pend_be0,
   input  logic [LANES-1:0]   pend_be1,
   input  logic [DW-1:0]      pend_d0,
   input  logic [DW-1:0]      pend_d1,
   output logic [DW-1:0]      dout,
   output logic               dout_vld
);

   logic               cap_v, mrg_v, dly_v, tail_v;
   logic [PAIR_AW-1:0] cap_pair;
   logic [DW-1:0]      mrg0, mrg1, mrg0_q, mrg1_q, dly0_q, dly1_q, tail_q;
   logic               hit;

   // Stage 1: accept a read only at the end of a K half.
   always_ff @(posedge clk) begin
      if (rst) cap_v <= 1'b0;
      else     cap_v <= k_half & rd_req;
      if (k_half) cap_pair <= rd_pair;
   end

   assign look_pair = cap_pair;
   assign hit       = pend_v && (pend_pair == cap_pair);

   // Byte-wise merge of the held write over the array contents.
   for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign mrg0[l*LANE_W +: LANE_W] = (hit && pend_be0[l]) ?
                                        pend_d0[l*LANE_W +: LANE_W] : arr0[l*LANE_W +: LANE_W];
      assign mrg1[l*LANE_W +: LANE_W] = (hit && pend_be1[l]) ?
                                        pend_d1[l*LANE_W +: LANE_W] : arr1[l*LANE_W +: LANE_W];
   end

   // Stages 2 and 3: carry the merged pair to the output half-cycle slot.
   always_ff @(posedge clk) begin
      if (rst) begin
         mrg_v <= 1'b0;
         dly_v <= 1'b0;
      end else begin
         mrg_v <= cap_v;
         dly_v <= mrg_v;
      end
      mrg0_q <= mrg0;
      mrg1_q <= mrg1;
      dly0_q <= mrg0_q;
      dly1_q <= mrg1_q;
   end

   // Output: beat 0 then beat 1 on consecutive clocks; hold when idle.
   always_ff @(posedge clk) begin
      if (rst) begin
         dout_vld <= 1'b0;
         tail_v   <= 1'b0;
         dout     <= '0;
      end else if (dly_v) begin
         dout_vld <= 1'b1;
         dout     <= dly0_q;
         tail_v   <= 1'b1;
      end else if (tail_v) begin
         dout_vld <= 1'b1;
         dout     <= tail_q;
         tail_v   <= 1'b0;
      end else begin
         dout_vld <= 1'b0;
         tail_v   <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (dly_v) tail_q <= dly1_q;
   end

   AST_FIRST_BEAT_LAT: assert property (@(posedge clk) disable iff (rst)
      (dout_vld && k_half) |-> $past(rd_req && k_half, 4)); // R6

   AST_BEATS_IN_PAIRS: assert property (@(posedge clk) disable iff (rst)
      (dout_vld && k_half) |=> dout_vld); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !dout_vld |-> $stable(dout)); // R7

   AST_NO_STRAY_BEAT: assert property (@(posedge clk) disable iff (rst)
      (dout_vld && !k_half) |-> $past(dout_vld)); // R2

endmodule

// File: rtl/burst2_qsram.sv
module burst2_qsram #(
   parameter  int WORD_AW = 10,
   parameter  int LANES   = 2,
   parameter  int LANE_W  = 9,
   localparam int PAIR_AW = WORD_AW - 1,
   localparam int DW      = LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst,
   output logic               k_half,
   input  logic               rd_req,
   input  logic [PAIR_AW-1:0] rd_pair,
   input  logic               wr_req,
   input  logic [PAIR_AW-1:0] wr_pair,
   input  logic [LANES-1:0]   lane_we,
   input  logic [DW-1:0]      din,
   output logic [DW-1:0]      dout,
   output logic               dout_vld
);
   import b2q_pkg::*;

   if (WORD_AW < 2 || WORD_AW > 16) begin : g_bad_word_aw
      $error("burst2_qsram: WORD_AW must lie in 2..16");
   end
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("burst2_qsram: LANES must lie in 1..16");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("burst2_qsram: LANE_W must be positive");
   end

   b2q_phase_e ph_q;

   always_ff @(posedge clk) begin
      if (rst) ph_q <= PH_K;
      else     ph_q <= (ph_q == PH_K) ? PH_KBAR : PH_K;
   end

   assign k_half = (ph_q == PH_K);

   logic               pend_v, commit_we;
   logic [PAIR_AW-1:0] pend_pair, look_pair;
   logic [LANES-1:0]   pend_be0, pend_be1;
   logic [DW-1:0]      pend_d0, pend_d1, arr0, arr1;

   b2q_wbuf #(.PAIR_AW(PAIR_AW), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
      .clk       (clk),
      .rst       (rst),
      .k_half    (k_half),
      .wr_req    (wr_req),
      .wr_pair   (wr_pair),
      .lane_we   (lane_we),
      .din       (din),
      .pend_v    (pend_v),
      .pend_pair (pend_pair),
      .pend_be0  (pend_be0),
      .pend_be1  (pend_be1),
      .pend_d0   (pend_d0),
      .pend_d1   (pend_d1),
      .commit_we (commit_we)
   );

   b2q_store #(.PAIR_AW(PAIR_AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk   (clk),
      .we    (commit_we),
      .wpair (pend_pair),
      .wbe0  (pend_be0),
      .wbe1  (pend_be1),
      .wd0   (pend_d0),
      .wd1   (pend_d1),
      .rpair (look_pair),
      .rd0   (arr0),
      .rd1   (arr1)
   );

   b2q_rpipe #(.PAIR_AW(PAIR_AW), .LANES(LANES), .LANE_W(LANE_W)) u_rpipe (
      .clk       (clk),
      .rst       (rst),
      .k_half    (k_half),
      .rd_req    (rd_req),
      .rd_pair   (rd_pair),
      .look_pair (look_pair),
      .arr0      (arr0),
      .arr1      (arr1),
      .pend_v    (pend_v),
      .pend_pair (pend_pair),
      .pend_be0  (pend_be0),
      .pend_be1  (pend_be1),
      .pend_d0   (pend_d0),
      .pend_d1   (pend_d1),
      .dout      (dout),
      .dout_vld  (dout_vld)
   );

   AST_PHASE_AFTER_RESET: assert property (@(posedge clk)
      $past(rst) |-> k_half); // R1

endmodule

// File: tb/burst2_qsram_bench.sv
module burst2_qsram_bench;
   localparam int WAW   = 10;
   localparam int LANES = 2;
   localparam int LW    = 9;
   localparam int DW    = LANES * LW;
   localparam int PAW   = WAW - 1;
   localparam int PAIRS = 1 << PAW;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           k_half;
   logic           rd_req = 1'b0;
   logic [PAW-1:0] rd_pair = '0;
   logic           wr_req = 1'b0;
   logic [PAW-1:0] wr_pair = '0;
   logic [LANES-1:0] lane_we = '0;
   logic [DW-1:0]  din = '0;
   logic [DW-1:0]  dout;
   logic           dout_vld;

   always #4 clk = ~clk;

   burst2_qsram #(.WORD_AW(WAW), .LANES(LANES), .LANE_W(LW)) u_burst2_qsram (
      .clk(clk), .rst(rst), .k_half(k_half),
      .rd_req(rd_req), .rd_pair(rd_pair),
      .wr_req(wr_req), .wr_pair(wr_pair),
      .lane_we(lane_we), .din(din),
      .dout(dout), .dout_vld(dout_vld)
   );

   int tests = 0;
   int fails = 0;
   int edge_cnt = 0;
   bit done = 1'b0;

   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   // Reference memory and expected-beat schedule, indexed by edge count.
   logic [DW-1:0] ref0 [PAIRS];
   logic [DW-1:0] ref1 [PAIRS];
   bit            ev [32];
   logic [DW-1:0] ed [32];
   string         et [32];
   bit            chk_on = 1'b0;
   bit            ph_exp = 1'b0;
   logic [DW-1:0] last_d = '0;
   int            ci;

   always @(negedge clk) begin
      if (chk_on) begin
         ci = edge_cnt % 32;
         tests++;
         if (ev[ci]) begin
            if (dout_vld !== 1'b1 || dout !== ed[ci]) begin
               fails++;
               $display("FAIL %s: beat vld=%0b dout=%h expected vld=1 dout=%h",
                        et[ci], dout_vld, dout, ed[ci]);
            end
            last_d = ed[ci];
         end else begin
            if (dout_vld !== 1'b0 || dout !== last_d) begin
               fails++;
               $display("FAIL R7: idle vld=%0b dout=%h expected vld=0 dout=%h",
                        dout_vld, dout, last_d);
            end
            last_d = dout;
         end
         ev[ci] = 1'b0;
         ph_exp = ~ph_exp;
         tests++;
         if (k_half !== ph_exp) begin
            fails++;
            $display("FAIL R2: k_half=%0b expected %0b", k_half, ph_exp);
         end
      end
   end

   function automatic logic [DW-1:0] pat(int p, int k);
      return DW'(p * 37 + k * 1013 + 5) ^ DW'(k * 18'h2a55a);
   endfunction

   task automatic cmd(input bit rd, input int ra, input bit wr, input int wa,
                      input logic [LANES-1:0] b0, input logic [DW-1:0] d0,
                      input logic [LANES-1:0] b1, input logic [DW-1:0] d1,
                      input string tag);
      int e;
      @(negedge clk);
      while (k_half !== 1'b1) @(negedge clk);
      rd_req  = rd;
      rd_pair = PAW'(ra);
      wr_req  = wr;
      lane_we = b0;
      din     = d0;
      e = edge_cnt + 1;
      if (rd) begin
         ev[(e + 3) % 32] = 1'b1;
         ed[(e + 3) % 32] = ref0[ra];
         et[(e + 3) % 32] = tag;
         ev[(e + 4) % 32] = 1'b1;
         ed[(e + 4) % 32] = ref1[ra];
         et[(e + 4) % 32] = tag;
      end
      if (wr) begin
         for (int l = 0; l < LANES; l++) begin
            if (b0[l]) ref0[wa][l*LW +: LW] = d0[l*LW +: LW];
            if (b1[l]) ref1[wa][l*LW +: LW] = d1[l*LW +: LW];
         end
      end
      @(negedge clk);
      rd_req  = 1'b0;
      wr_req  = 1'b0;
      wr_pair = PAW'(wa);
      lane_we = b1;
      din     = d1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cmd(0, 0, 0, 0, '0, '0, '0, '0, "R7");
   endtask

   // Requests raised only in a K# half must be ignored (R2).
   task automatic stray(input int a);
      @(negedge clk);
      while (k_half !== 1'b1) @(negedge clk);
      rd_req = 1'b0; wr_req = 1'b0; lane_we = '0;
      @(negedge clk);
      rd_req = 1'b1; rd_pair = PAW'(a);
      wr_req = 1'b1; wr_pair = PAW'(a);
      lane_we = '1;  din = '1;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) ev[i] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      tests++;
      if (k_half !== 1'b1 || dout_vld !== 1'b0 || dout !== '0) begin
         fails++;
         $display("FAIL R1: in reset k_half=%0b vld=%0b dout=%h expected 1 0 0",
                  k_half, dout_vld, dout);
      end
      @(posedge clk);
      #1 rst = 1'b0;
      chk_on = 1'b1;
      tests++;
      if (k_half !== 1'b1 || dout_vld !== 1'b0 || dout !== '0) begin
         fails++;
         $display("FAIL R1: after reset k_half=%0b vld=%0b dout=%h expected 1 0 0",
                  k_half, dout_vld, dout);
      end

      // R4: fill every pair with distinct beats, then read a spread back.
      for (int p = 0; p < PAIRS; p++) cmd(0, 0, 1, p, '1, pat(p, 0), '1, pat(p, 1), "R4");
      idle(2);
      for (int p = 0; p < PAIRS; p += 61) begin
         cmd(1, p, 0, 0, '0, '0, '0, '0, "R6");
         idle(2);
      end

      // R10: back-to-back reads.
      for (int p = 100; p < 116; p++) cmd(1, p, 0, 0, '0, '0, '0, '0, "R10");
      idle(3);

      // R5: per-lane masks and an all-off write.
      cmd(0, 0, 1, 7, 2'b01, 18'h3ffff, 2'b10, 18'h15555, "R5");
      idle(2);
      cmd(1, 7, 0, 0, '0, '0, '0, '0, "R5");
      cmd(0, 0, 1, 8, 2'b00, 18'h12345, 2'b00, 18'h0abcd, "R5");
      idle(2);
      cmd(1, 8, 0, 0, '0, '0, '0, '0, "R5");
      idle(3);

      // R8 and R9: same-cycle read/write, then reads that hit the held write.
      cmd(1, 20, 1, 20, '1, 18'h00111, '1, 18'h00222, "R8");
      cmd(1, 20, 0, 0, '0, '0, '0, '0, "R9");
      cmd(0, 0, 1, 30, 2'b10, 18'h2f0f0, 2'b11, 18'h0c3c3, "R9");
      cmd(1, 30, 0, 0, '0, '0, '0, '0, "R9");
      cmd(0, 0, 1, 31, '1, 18'h31313, '1, 18'h13131, "R9");
      cmd(0, 0, 1, 32, '1, 18'h32323, '1, 18'h23232, "R9");
      cmd(1, 31, 1, 31, 2'b01, 18'h0000f, 2'b10, 18'h3f000, "R8");
      cmd(1, 31, 0, 0, '0, '0, '0, '0, "R9");
      idle(3);

      // R2: misplaced requests change nothing and return nothing.
      stray(40);
      idle(4);
      cmd(1, 40, 0, 0, '0, '0, '0, '0, "R2");
      idle(3);

      // R9: random collisions over a small address window.
      for (int i = 0; i < 3000; i++) begin
         cmd(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
             bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
             LANES'($urandom_range(0, 3)), DW'($urandom),
             LANES'($urandom_range(0, 3)), DW'($urandom), "R9");
      end
      idle(6);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule